// File: doc/BRIEF.md
# Streaming IQ Demodulator

This block takes a stream of real, signed 16-bit samples and produces a stream of complex baseband values. Every accepted sample goes to two paths that are built the same way. Each path multiplies the sample by a local oscillator and then low-pass filters the product. One path uses a cosine oscillator and produces I. The other uses a sine oscillator and produces Q. The filter removes the term at twice the carrier frequency and keeps the slowly varying term. Each filtered value is brought down to 16 bits, and the two values are packed into one 32-bit output word.

The carrier is fixed at one tenth of the sample rate (for example, 10 MHz at 100 MHz sampling). The oscillator phase steps once for each accepted input sample and never on idle cycles. Both paths move in lock step, so the input-ready and output-valid signals come from the I path alone. The filter has 16 taps, and its response has exact zeros at twice and four times the carrier. A gain of two after the filter makes up for the factor of one half that mixing introduces. A constant-amplitude input at angle phi therefore yields I ≈ A·cos(phi)·G and Q ≈ −A·sin(phi)·G, where G = (32600/16384)·0.5·(32767/32768).

Top module: `iq_demod`

## Requirements
- R1: The I path and the Q path receive the same input beat in the same cycle. Their ready and valid signals stay equal in every cycle.
- R2: Output bits [31:16] hold I and bits [15:0] hold Q. Both are 16-bit two's complement.
- R3: In steady state, for an input x[n] = A·cos(2πn/10 + phi), I lies within 60 LSB of A·cos(phi)·G.
- R4: Under the same conditions, Q lies within 60 LSB of −A·sin(phi)·G.
- R5: Under the same conditions, sqrt(I²+Q²) lies within 60 LSB of A·G, whatever the value of phi.
- R6: A filtered value above 32767 saturates to exactly 32767. It does not wrap.
- R7: A filtered value below −32768 saturates to exactly −32768. It does not wrap.
- R8: Exactly one output beat is produced for each accepted input beat, in the same order. An output that is held back by a low TREADY keeps its data and its valid.
- R9: While reset is active and on the first cycle after it, output valid is 0 and input ready is 1.
- R10: The oscillator phase and the filter history advance only on accepted beats. Gaps in TVALID and stalls on TREADY do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_axis_tvalid | input | 1 | Input sample valid |
| s_axis_tready | output | 1 | Input sample accepted (taken from the I path) |
| s_axis_tdata | input | 16 | Real input sample, two's complement |
| m_axis_tvalid | output | 1 | Output word valid (taken from the I path) |
| m_axis_tready | input | 1 | Downstream ready |
| m_axis_tdata | output | 32 | Packed word: I in [31:16], Q in [15:0] |

## Verification
A wrong oscillator phase shows up as a rotation of the (I, Q) pair. If the phase slips on an idle cycle, that rotation appears within 17 output beats. A corrupted filter history or a wrong coefficient breaks the constant magnitude, or leaves ripple at twice the carrier, during the 16 beats that the history takes to flush. A saturation fault shows at once as a wrapped sign on a full-scale input. If the two paths fall out of lock step, a beat is dropped or duplicated, and the output count differs from the input count at the end of the stream.

// File: rtl/iqd_pkg.sv
// Shared constants and helpers for the IQ demodulator.
// Assumes the carrier is fixed at one tenth of the sample rate.
package iqd_pkg;
    localparam int LO_STEPS = 10;
    localparam int LO_FRAC  = 15;

    typedef enum logic {LO_COS = 1'b0, LO_SIN = 1'b1} lo_kind_e;

    // Q15 cosine at angle 2*pi*k/10
    function automatic logic signed [15:0] cos_q15(input int k);
        case (k)
            0:       return 16'sd32767;
            1, 9:    return 16'sd26509;
            2, 8:    return 16'sd10126;
            3, 7:    return -16'sd10126;
            4, 6:    return -16'sd26509;
            default: return -16'sd32767;
        endcase
    endfunction

    // Q15 sine at angle 2*pi*k/10
    function automatic logic signed [15:0] sin_q15(input int k);
        case (k)
            1, 4:    return 16'sd19260;
            2, 3:    return 16'sd31163;
            6, 9:    return -16'sd19260;
            7, 8:    return -16'sd31163;
            default: return 16'sd0;
        endcase
    endfunction

    // Low-pass tap: a 9-tap triangle convolved with an 8-tap box, then scaled.
    // This gives zeros at fs/5 and 2*fs/5, and the taps sum to 200*scale.
    function automatic int lp_tap(input int i, input int scale);
        int acc;
        acc = 0;
        for (int j = 0; j < 8; j++) begin
            int m;
            m = i - j;
            if (m >= 0 && m <= 8)
                acc += (m <= 4) ? (m + 1) : (9 - m);
        end
        return acc * scale;
    endfunction
endpackage

// File: rtl/iqd_mixer.sv
// Quadrature mixer stage with a one-deep output register.
// Multiplies each accepted sample by a cosine or sine LO (chosen by KIND),
// and steps the LO phase only on accepted beats.
// Assumes the sample width is no larger than LO_FRAC+1.
module iqd_mixer
    import iqd_pkg::*;
#(
    parameter int       W    = 16,
    parameter lo_kind_e KIND = LO_COS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic signed [W-1:0] s_data,
    output logic                m_valid,
    input  logic                m_ready,
    output logic signed [W-1:0] m_data
);
    localparam int PH_W   = $clog2(LO_STEPS);
    localparam int PROD_W = W + 16;

    logic [PH_W-1:0]          phase;
    logic signed [15:0]       lo;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic                     take;

    // Select the oscillator variant
    generate
        if (KIND == LO_COS) begin : g_cos
            always_comb lo = cos_q15(int'(phase));
        end else begin : g_sin
            always_comb lo = sin_q15(int'(phase));
        end
    endgenerate

    // Mixer product in Q15
    always_comb begin
        prod   = PROD_W'(s_data) * PROD_W'(lo);
        scaled = prod >>> LO_FRAC;
    end

    assign s_ready = !m_valid || m_ready;
    assign take    = s_valid && s_ready;

    // Output register and LO phase step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            m_valid <= 1'b0;
            m_data  <= '0;
        end else begin
            if (s_ready) m_valid <= s_valid;
            if (take) begin
                m_data <= scaled[W-1:0];
                phase  <= (phase == PH_W'(LO_STEPS - 1)) ? '0 : phase + 1'b1;
            end
        end
    end

    // R8
    mix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
    // R10
    lo_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> $stable(phase));
endmodule

// File: rtl/iqd_lowpass.sv
// Streaming 16-tap symmetric low-pass FIR with a saturating 16-bit output.
// On each accepted beat it shifts the history and registers the filtered
// value of the new window. Expects TAPS = 16 to match the tap function.
module iqd_lowpass
    import iqd_pkg::*;
#(
    parameter int W     = 16,
    parameter int TAPS  = 16,
    parameter int SCALE = 163,
    parameter int SHIFT = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic signed [W-1:0] s_data,
    output logic                m_valid,
    input  logic                m_ready,
    output logic signed [W-1:0] m_data
);
    localparam int ACC_W = 2 * W + $clog2(TAPS) + 1;
    localparam logic signed [ACC_W-1:0] POS_MAX = ACC_W'((1 << (W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_MIN = -ACC_W'(1 << (W - 1));

    logic signed [W-1:0]     hist [TAPS-1];
    logic signed [W-1:0]     win  [TAPS];
    logic signed [ACC_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] shifted;
    logic signed [W-1:0]     clipped;
    logic                    take;

    // Window = newest sample followed by the history
    assign win[0] = s_data;
    generate
        for (genvar g = 1; g < TAPS; g++) begin : g_win
            assign win[g] = hist[g-1];
        end
        for (genvar g = 0; g < TAPS; g++) begin : g_tap
            localparam logic signed [ACC_W-1:0] COEF = ACC_W'(lp_tap(g, SCALE));
            assign prod[g] = ACC_W'(win[g]) * COEF;
        end
    endgenerate

    // Sum the products, scale, and saturate to W bits
    always_comb begin
        acc = '0;
        for (int i = 0; i < TAPS; i++) acc = acc + prod[i];
        shifted = acc >>> SHIFT;
        if (shifted > POS_MAX)      clipped = POS_MAX[W-1:0];
        else if (shifted < NEG_MIN) clipped = NEG_MIN[W-1:0];
        else                        clipped = shifted[W-1:0];
    end

    assign s_ready = !m_valid || m_ready;
    assign take    = s_valid && s_ready;

    // History shift and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            for (int i = 0; i < TAPS - 1; i++) hist[i] <= '0;
        end else begin
            if (s_ready) m_valid <= s_valid;
            if (take) begin
                m_data  <= clipped;
                hist[0] <= s_data;
                for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
            end
        end
    end

    // R8
    fir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
    // R10
    fir_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> $stable(hist[0]));
endmodule

// File: rtl/iq_demod.sv
// IQ demodulator top level. It broadcasts each sample to a cosine path and a
// sine path (mixer followed by low-pass filter), then packs I over Q.
// Assumes both paths stay in lock step, so the handshake comes from the I path.
module iq_demod
    import iqd_pkg::*;
#(
    parameter int W     = 16,
    parameter int TAPS  = 16,
    parameter int SCALE = 163,
    parameter int SHIFT = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_axis_tvalid,
    output logic             s_axis_tready,
    input  logic [W-1:0]     s_axis_tdata,
    output logic             m_axis_tvalid,
    input  logic             m_axis_tready,
    output logic [2*W-1:0]   m_axis_tdata
);
    logic                p_in_ready  [2];
    logic                p_mid_valid [2];
    logic                p_mid_ready [2];
    logic signed [W-1:0] p_mid_data  [2];
    logic                p_out_valid [2];
    logic signed [W-1:0] p_out_data  [2];

    // Two identical paths: index 0 gives I, index 1 gives Q
    generate
        for (genvar p = 0; p < 2; p++) begin : g_path
            localparam lo_kind_e KIND = (p == 0) ? LO_COS : LO_SIN;
            iqd_mixer #(.W(W), .KIND(KIND)) u_mix (
                .clk(clk), .rst_n(rst_n),
                .s_valid(s_axis_tvalid), .s_ready(p_in_ready[p]),
                .s_data(signed'(s_axis_tdata)),
                .m_valid(p_mid_valid[p]), .m_ready(p_mid_ready[p]),
                .m_data(p_mid_data[p])
            );
            iqd_lowpass #(.W(W), .TAPS(TAPS), .SCALE(SCALE), .SHIFT(SHIFT)) u_lp (
                .clk(clk), .rst_n(rst_n),
                .s_valid(p_mid_valid[p]), .s_ready(p_mid_ready[p]),
                .s_data(p_mid_data[p]),
                .m_valid(p_out_valid[p]), .m_ready(m_axis_tready),
                .m_data(p_out_data[p])
            );
        end
    endgenerate

    assign s_axis_tready = p_in_ready[0];
    assign m_axis_tvalid = p_out_valid[0];
    assign m_axis_tdata  = {p_out_data[0], p_out_data[1]};

    // R1
    lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_in_ready[0] == p_in_ready[1]) && (p_out_valid[0] == p_out_valid[1]));
    // R9
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!m_axis_tvalid && s_axis_tready));
endmodule

// File: tb/iq_demod_test.sv
module iq_demod_test;
    localparam int SEG   = 40;
    localparam int NVEC  = 6;
    localparam int NSEG  = NVEC + 2;
    localparam int N     = NSEG * SEG;
    localparam int TOL   = 60;
    localparam int LIMIT = 20000;
    localparam real PI   = 3.14159265358979;
    localparam real G    = (32600.0 / 16384.0) * 0.5 * (32767.0 / 32768.0);

    // Stimulus table: amplitude and phase in degrees
    localparam int VEC_AMP [NVEC] = '{10000, 10000, 10000, 20000, 5000, 14000};
    localparam int VEC_PH  [NVEC] = '{0, 90, 180, 45, 300, 200};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        s_valid, s_ready, m_valid, m_ready;
    logic [15:0] s_data;
    logic [31:0] m_data;

    int checks = 0;
    int fails  = 0;
    int xin  [N];
    logic [31:0] outs [N];

    always #5 clk = ~clk;

    iq_demod uut (
        .clk(clk), .rst_n(rst_n),
        .s_axis_tvalid(s_valid), .s_axis_tready(s_ready), .s_axis_tdata(s_data),
        .m_axis_tvalid(m_valid), .m_axis_tready(m_ready), .m_axis_tdata(m_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    initial begin
        int  sent, got, cyc;
        bit  fire_in, fire_out;
        logic [31:0] cap;

        // Build the input: table segments, then +full-scale and -full-scale rectified segments
        for (int n = 0; n < N; n++) begin
            int sg;
            sg = n / SEG;
            if (sg < NVEC)
                xin[n] = int'(VEC_AMP[sg] * $cos(2.0 * PI * n / 10.0 + VEC_PH[sg] * PI / 180.0));
            else begin
                int k;
                k = n % 10;
                xin[n] = ((k <= 2 || k >= 8) ? 32767 : -32767) * ((sg == NVEC) ? 1 : -1);
            end
        end

        rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0; s_data = '0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(m_valid == 1'b0, "R9 valid in reset", int'(m_valid), 0);
        check(s_ready == 1'b1, "R9 ready in reset", int'(s_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_valid == 1'b0, "R9 valid after reset", int'(m_valid), 0);

        sent = 0; got = 0; cyc = 0; fire_in = 0; fire_out = 0; cap = '0;
        while (got < N && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (fire_in) sent++;
            if (fire_out) begin
                outs[got] = cap;
                got++;
            end
            // R10: gaps in valid and stalls in ready
            s_valid = (sent < N) && (cyc % 5 != 0);
            s_data  = (sent < N) ? 16'(xin[sent]) : 16'h0;
            m_ready = (cyc % 7 != 0);
            #1;
            fire_in  = s_valid && s_ready;
            fire_out = m_valid && m_ready;
            cap      = m_data;
        end
        s_valid = 1'b0;

        if (cyc >= LIMIT) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", got, N);
        end

        // R8: beat count
        check(got == N && sent == N, "R8 beat count", got, sent);

        // Table walk
        for (int sg = 0; sg < NVEC; sg++) begin
            real ei, eq;
            ei = VEC_AMP[sg] * $cos(VEC_PH[sg] * PI / 180.0) * G;
            eq = -VEC_AMP[sg] * $sin(VEC_PH[sg] * PI / 180.0) * G;
            for (int j = sg * SEG + 20; j < (sg + 1) * SEG; j++) begin
                int iv, qv, mag;
                iv  = int'($signed(outs[j][31:16]));
                qv  = int'($signed(outs[j][15:0]));
                mag = int'($sqrt(real'(iv) * iv + real'(qv) * qv));
                check(absi(iv - int'(ei)) <= TOL, "R3/R10 I value", iv, int'(ei));
                check(absi(qv - int'(eq)) <= TOL, "R4 Q value", qv, int'(eq));
                check(absi(mag - int'(VEC_AMP[sg] * G)) <= TOL, "R5 magnitude", mag, int'(VEC_AMP[sg] * G));
            end
        end

        // R2: at 90 degrees the energy is in the low half, and negative
        check(absi(int'($signed(outs[SEG + 30][31:16]))) <= TOL && int'($signed(outs[SEG + 30][15:0])) < -9000,
              "R2 packing", int'($signed(outs[SEG + 30][15:0])), int'(-10000 * G));

        // R6 / R7 saturation
        for (int j = NVEC * SEG + 20; j < (NVEC + 1) * SEG; j++) begin
            check(int'($signed(outs[j][31:16])) == 32767, "R6 positive clip", int'($signed(outs[j][31:16])), 32767);
            check(absi(int'($signed(outs[j][15:0]))) <= TOL, "R6 Q near zero", int'($signed(outs[j][15:0])), 0);
        end
        for (int j = (NVEC + 1) * SEG + 20; j < N; j++)
            check(int'($signed(outs[j][31:16])) == -32768, "R7 negative clip", int'($signed(outs[j][31:16])), -32768);

        // R1: both halves respond together (Q in the I-only segment stays near zero)
        check(absi(int'($signed(outs[30][15:0]))) <= TOL, "R1 Q path aligned", int'($signed(outs[30][15:0])), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule